// File: doc/BRIEF.md
# SLC96 Receive Data Link Capture

This block sits behind a T1 framer running in the SLC96 superframe format. It takes the data link bits one at a time, each on a bit strobe, and assembles each 36-bit link message into six stored octets. Every octet holds six message bits in its low six positions. Two six-octet banks take turns: each new message goes into the bank that did not receive the previous completed message. A processor can therefore read one finished message while the next one is arriving.

Three sticky status flags report the start of a message, the completion of a message, and an abort. An abort is a run of six consecutive one bits, which halts capture. Each flag has its own enable bit. A block-level enable input gates the combined interrupt. A small register read port exposes both banks, the status register and the control register. Reading the status register clears its flags. Superframe alignment is done upstream and arrives as a message-start strobe that comes with the first bit of each message.

Top module: `slc96_dl_rx`

## Requirements
- R1: When `mode_slc96` is 0, incoming bits cause no buffer write and no status flag is set. Dropping the mode also cancels a message in progress and clears the run-of-ones count.
- R2: Message bits fill octets 1 to 6 in order, each octet from bit 5 down to bit 0. Octet k of bank 0 reads at address k-1 (0x0 to 0x5). Octet k of bank 1 reads at address 0x8+k-1 (0x8 to 0xD).
- R3: Bits 7 and 6 of every octet read back as 0.
- R4: A message begun with `msg_start` is written into the bank opposite to the one recorded as holding the last completed message. That record is status bit 3. It resets to 1, so the first message lands in bank 0, and it changes only when a message completes.
- R5: The start flag (status bit 0) is set by a bit strobe that carries `msg_start`.
- R6: The end flag (status bit 1) is set after the 36th bit of a message is stored.
- R7: Six consecutive received one bits, counted over every accepted bit, set the abort flag (status bit 2). The sixth bit is not stored and the message in progress is dropped. All later bits are ignored until a control write with bit 7 set re-arms capture.
- R8: `irq` is 1 exactly when `blk_irq_en` is 1 and at least one status flag 0 to 2 is set whose enable bit is set. The enables are bits 0 to 2 of the control register at address 0x7, and that register reads back its enables.
- R9: A read of the status register at address 0x6 returns the pre-read value one cycle later and clears flags 0 to 2. A flag set in the same cycle as the read survives. Status bit 3 is never cleared.
- R10: A `msg_start` strobe during a message restarts filling at octet 1, bit 5, of the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_slc96 | input | 1 | Framing mode is SLC96 |
| bit_vld | input | 1 | A data link bit is present this cycle |
| bit_in | input | 1 | Data link bit value |
| msg_start | input | 1 | This bit is the first bit of a message |
| blk_irq_en | input | 1 | Block-level data link interrupt enable |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data (control register only) |
| rd_data | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bank pointer shows up at the next status read, where bit 3 is wrong. It also shows as a freshly captured message appearing in the octets of the wrong bank. A wrong position count shows as misplaced bits in the octet reads. It also makes the end-of-message interrupt appear a cycle early or late relative to the 36th strobe, and since `irq` is compared on every cycle, that shows up within one clock. A wrong run-of-ones count or halt state shows the same way: as an abort interrupt at the wrong strobe, or as later messages that are stored, or not stored, against expectation.

// File: rtl/slc96_pkg.sv
package slc96_pkg;

    localparam int OCT_W     = 6;
    localparam int N_OCT     = 6;
    localparam int MSG_BITS  = OCT_W * N_OCT;
    localparam int RUN_MAX   = 6;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int POS_W     = $clog2(MSG_BITS);
    localparam int OIDX_W    = $clog2(N_OCT);
    localparam int BIDX_W    = $clog2(OCT_W);

    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h6;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h7;
    localparam int REARM_BIT = 7;

    // flag order: bit0 start, bit1 end, bit2 abort
    typedef struct packed {
        logic abt;
        logic eot;
        logic sot;
    } flags_t;

    typedef struct packed {
        logic              en;
        logic              bank;
        logic [OIDX_W-1:0] oct;
        logic [BIDX_W-1:0] bitp;
        logic              val;
    } bitwr_t;

    function automatic logic [OIDX_W-1:0] oct_of(input logic [POS_W-1:0] pos);
        int p;
        p = int'(pos);
        return OIDX_W'(p / OCT_W);
    endfunction

    function automatic logic [BIDX_W-1:0] bit_of(input logic [POS_W-1:0] pos);
        int p;
        p = int'(pos);
        return BIDX_W'(OCT_W - 1 - (p % OCT_W));
    endfunction

endpackage

// File: rtl/slc96_bit_asm.sv
module slc96_bit_asm
    import slc96_pkg::*;
#(
    parameter int RUN_LEN = RUN_MAX
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   mode_on,
    input  logic   bit_vld,
    input  logic   bit_in,
    input  logic   msg_start,
    input  logic   rearm,
    output bitwr_t wr,
    output flags_t ev,
    output logic   last_bank
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(MSG_BITS - 1);

    logic             busy_q;
    logic             halt_q;
    logic             tgt_q;
    logic             last_q;
    logic [POS_W-1:0] pos_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nx;
    logic             hit;
    logic             take;

    assign take   = mode_on && bit_vld && !halt_q && !rearm;
    assign run_nx = bit_in ? run_q + 1'b1 : '0;
    assign hit    = (run_nx == RUN_W'(RUN_LEN));

    always_comb begin
        wr = '0;
        ev = '0;
        if (take && hit) begin
            ev.abt = 1'b1;
        end else if (take && msg_start) begin
            wr.en   = 1'b1;
            wr.bank = ~last_q;
            wr.oct  = oct_of('0);
            wr.bitp = bit_of('0);
            wr.val  = bit_in;
            ev.sot  = 1'b1;
        end else if (take && busy_q) begin
            wr.en   = 1'b1;
            wr.bank = tgt_q;
            wr.oct  = oct_of(pos_q);
            wr.bitp = bit_of(pos_q);
            wr.val  = bit_in;
            ev.eot  = (pos_q == LAST_POS);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            halt_q <= 1'b0;
            tgt_q  <= 1'b0;
            last_q <= 1'b1;
            pos_q  <= '0;
            run_q  <= '0;
        end else if (rearm) begin
            halt_q <= 1'b0;
            busy_q <= 1'b0;
            run_q  <= '0;
        end else if (!mode_on) begin
            busy_q <= 1'b0;
            run_q  <= '0;
        end else if (take) begin
            if (hit) begin
                halt_q <= 1'b1;
                busy_q <= 1'b0;
                run_q  <= '0;
            end else begin
                run_q <= run_nx;
                if (msg_start) begin
                    busy_q <= 1'b1;
                    tgt_q  <= ~last_q;
                    pos_q  <= POS_W'(1);
                end else if (busy_q) begin
                    if (pos_q == LAST_POS) begin
                        busy_q <= 1'b0;
                        last_q <= tgt_q;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
            end
        end
    end

    assign last_bank = last_q;

endmodule

// File: rtl/slc96_msg_buf.sv
module slc96_msg_buf
    import slc96_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bitwr_t            wr,
    input  logic              rd_bank,
    input  logic [OIDX_W-1:0] rd_oct,
    output logic [OCT_W-1:0]  rd_oct_data
);
    localparam int N_BANK = 2;

    logic [OCT_W-1:0] mem [N_BANK][N_OCT];

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        for (genvar o = 0; o < N_OCT; o++) begin : g_oct
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[b][o] <= '0;
                end else if (wr.en && (wr.bank == 1'(b)) && (wr.oct == OIDX_W'(o))) begin
                    mem[b][o][wr.bitp] <= wr.val;
                end
            end
        end
    end

    always_comb begin
        rd_oct_data = '0;
        for (int o = 0; o < N_OCT; o++) begin
            if (rd_oct == OIDX_W'(o)) rd_oct_data = mem[rd_bank][o];
        end
    end

endmodule

// File: rtl/slc96_regs.sv
module slc96_regs
    import slc96_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  flags_t            ev,
    input  logic              last_bank,
    input  logic              blk_ie,
    input  logic [OCT_W-1:0]  oct_data,
    output logic              rd_bank,
    output logic [OIDX_W-1:0] rd_oct,
    output logic [DATA_W-1:0] rd_data,
    output logic              rearm,
    output flags_t            stat,
    output logic              irq
);
    localparam int NF = $bits(flags_t);

    flags_t            stat_q;
    logic [NF-1:0]     en_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_mux;
    logic              rd_stat;
    logic              wr_ctrl;
    logic              is_oct;
    logic              unused_wdata;

    assign rd_bank      = reg_addr[ADDR_W-1];
    assign rd_oct       = reg_addr[OIDX_W-1:0];
    assign is_oct       = (rd_oct < OIDX_W'(N_OCT));
    assign rd_stat      = reg_rd && (reg_addr == ADDR_STAT);
    assign wr_ctrl      = reg_wr && (reg_addr == ADDR_CTRL);
    assign rearm        = wr_ctrl && reg_wdata[REARM_BIT];
    assign unused_wdata = ^reg_wdata[REARM_BIT-1:NF];

    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_STAT) begin
            rd_mux = DATA_W'({last_bank, stat_q});
        end else if (reg_addr == ADDR_CTRL) begin
            rd_mux = DATA_W'(en_q);
        end else if (is_oct) begin
            rd_mux = DATA_W'(oct_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
            rd_q   <= '0;
        end else begin
            stat_q <= (rd_stat ? flags_t'('0) : stat_q) | ev;
            if (wr_ctrl) en_q <= reg_wdata[NF-1:0];
            if (reg_rd) rd_q <= rd_mux;
        end
    end

    assign rd_data = rd_q;
    assign stat    = stat_q;
    assign irq     = blk_ie && (|(stat_q & en_q));

endmodule

// File: rtl/slc96_dl_rx.sv
module slc96_dl_rx
    import slc96_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_slc96,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              msg_start,
    input  logic              blk_irq_en,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    bitwr_t            wr;
    flags_t            ev;
    flags_t            stat_bits;
    logic              last_bank;
    logic              rearm;
    logic              rd_bank;
    logic [OIDX_W-1:0] rd_oct;
    logic [OCT_W-1:0]  oct_data;

    slc96_bit_asm #(.RUN_LEN(RUN_MAX)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .mode_on   (mode_slc96),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .msg_start (msg_start),
        .rearm     (rearm),
        .wr        (wr),
        .ev        (ev),
        .last_bank (last_bank)
    );

    slc96_msg_buf u_buf (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .rd_bank     (rd_bank),
        .rd_oct      (rd_oct),
        .rd_oct_data (oct_data)
    );

    slc96_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ev        (ev),
        .last_bank (last_bank),
        .blk_ie    (blk_irq_en),
        .oct_data  (oct_data),
        .rd_bank   (rd_bank),
        .rd_oct    (rd_oct),
        .rd_data   (rd_data),
        .rearm     (rearm),
        .stat      (stat_bits),
        .irq       (irq)
    );

endmodule

// File: rtl/slc96_dl_rx_chk.sv
module slc96_dl_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_slc96,
    input logic       blk_irq_en,
    input logic       irq,
    input logic [7:0] rd_data,
    input logic [2:0] stat_bits,
    input logic       last_bank
);
    a_r8_irq_needs_blk: assert property (@(posedge clk) disable iff (rst)
        irq |-> blk_irq_en);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b00);

    a_r1_sot_in_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_bits[0]) |-> $past(mode_slc96));

    a_r1_eot_in_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_bits[1]) |-> $past(mode_slc96));

    a_r7_abt_in_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_bits[2]) |-> $past(mode_slc96));

    a_r4_flip_with_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(last_bank) |-> stat_bits[1]);

endmodule

bind slc96_dl_rx slc96_dl_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_slc96 (mode_slc96),
    .blk_irq_en (blk_irq_en),
    .irq        (irq),
    .rd_data    (rd_data),
    .stat_bits  (stat_bits),
    .last_bank  (last_bank)
);

// File: tb/slc96_dl_rx_tb_top.sv
module slc96_dl_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_slc96 = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       msg_start = 1'b0;
    logic       blk_irq_en = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    always #2.5 clk = ~clk;

    slc96_dl_rx dut_i (
        .clk(clk), .rst(rst), .mode_slc96(mode_slc96), .bit_vld(bit_vld),
        .bit_in(bit_in), .msg_start(msg_start), .blk_irq_en(blk_irq_en),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .irq(irq)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    done   = 0;
    string tag    = "reset";

    // behavioural reference model
    int    mbuf [2][6];
    bit    m_busy, m_halt, m_tgt, m_last;
    int    m_pos, m_run;
    bit    f_sot, f_eot, f_abt;
    int    m_en;
    bit    rd_pend;
    int    exp_rd;
    string exp_tag;

    function automatic int mread(input int a);
        if ((a % 8) < 6) return mbuf[a / 8][a % 8];
        if (a == 6) return (int'(m_last) << 3) | (int'(f_abt) << 2) | (int'(f_eot) << 1) | int'(f_sot);
        if (a == 7) return m_en;
        return 0;
    endfunction

    task automatic mstore(input bit b, input int p, input bit v);
        int o;
        int k;
        o = p / 6;
        k = 5 - (p % 6);
        if (v) mbuf[b][o] = mbuf[b][o] | (1 << k);
        else   mbuf[b][o] = mbuf[b][o] & ~(1 << k);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int b = 0; b < 2; b++) for (int o = 0; o < 6; o++) mbuf[b][o] = 0;
            m_busy = 0; m_halt = 0; m_tgt = 0; m_last = 1; m_pos = 0; m_run = 0;
            f_sot = 0; f_eot = 0; f_abt = 0; m_en = 0; rd_pend = 0; exp_rd = 0;
        end else begin
            bit e_sot, e_eot, e_abt, re, tk;
            int nr;
            e_sot = 0; e_eot = 0; e_abt = 0;
            rd_pend = reg_rd;
            if (reg_rd) begin
                exp_rd  = mread(int'(reg_addr));
                exp_tag = tag;
            end
            re = reg_wr && reg_addr == 4'h7 && reg_wdata[7];
            tk = mode_slc96 && bit_vld && !m_halt && !re;
            if (re) begin
                m_halt = 0; m_run = 0; m_busy = 0;
            end else if (!mode_slc96) begin
                m_busy = 0; m_run = 0;
            end else if (tk) begin
                nr = bit_in ? m_run + 1 : 0;
                if (nr == 6) begin
                    e_abt = 1; m_halt = 1; m_busy = 0; m_run = 0;
                end else begin
                    m_run = nr;
                    if (msg_start) begin
                        m_tgt = !m_last; mstore(m_tgt, 0, bit_in);
                        m_busy = 1; m_pos = 1; e_sot = 1;
                    end else if (m_busy) begin
                        mstore(m_tgt, m_pos, bit_in);
                        if (m_pos == 35) begin
                            m_busy = 0; m_last = m_tgt; e_eot = 1;
                        end else m_pos++;
                    end
                end
            end
            if (reg_rd && reg_addr == 4'h6) begin
                f_sot = 0; f_eot = 0; f_abt = 0;
            end
            f_sot |= e_sot; f_eot |= e_eot; f_abt |= e_abt;
            if (reg_wr && reg_addr == 4'h7) m_en = int'(reg_wdata[2:0]);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ei;
            ei = blk_irq_en && ((f_sot && m_en[0]) || (f_eot && m_en[1]) || (f_abt && m_en[2]));
            checks++;
            if (irq !== ei) begin
                fails++;
                $display("FAIL R8 irq (%s) actual=%0b expected=%0b at cycle %0d", tag, irq, ei, cycles);
            end
            if (rd_pend) begin
                checks++;
                if (int'(rd_data) !== exp_rd) begin
                    fails++;
                    $display("FAIL %s rd_data actual=%02h expected=%02h", exp_tag, rd_data, exp_rd[7:0]);
                end
            end
        end
    end

    function automatic logic [35:0] mk(input logic [11:1] c, input logic [1:0] a,
                                       input logic [2:0] m, input logic [3:0] s);
        return {6'b011100, c[1], 5'b11100, c[7:2], 2'b10, c[11:8], a, m, 1'b0, 2'b01, s};
    endfunction

    task automatic send_msg(input logic [35:0] msg, input int nbits, input int gap);
        for (int i = 0; i < nbits; i++) begin
            bit_vld = 1; bit_in = msg[35-i]; msg_start = (i == 0);
            @(negedge clk);
            bit_vld = 0; msg_start = 0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) begin
            bit_vld = 1; bit_in = 1;
            @(negedge clk);
        end
        bit_vld = 0; bit_in = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1; reg_addr = 4'h7; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_bank(input int b);
        for (int o = 0; o < 6; o++) rd(4'(b * 8 + o));
    endtask

    task automatic finish_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [35:0] m1, m2, m3;
        m1 = mk(11'h2A5, 2'b01, 3'b101, 4'h9);
        m2 = mk(11'h5DA, 2'b10, 3'b011, 4'h6);
        m3 = mk(11'h1C3, 2'b00, 3'b110, 4'hA);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tag = "R9 reset"; rd(4'h6);
        tag = "R8 reset"; rd(4'h7);
        tag = "R2 R3 reset"; rd_bank(0);

        wr(8'h03); blk_irq_en = 1; mode_slc96 = 1;
        @(negedge clk);
        tag = "R5 R6 R2"; send_msg(m1, 36, 0);
        @(negedge clk);
        tag = "R9 R6"; rd(4'h6);
        tag = "R9 clear"; rd(4'h6);
        tag = "R2 R3"; rd_bank(0);

        tag = "R4"; send_msg(m2, 36, 1);
        rd(4'h6); rd_bank(1); rd_bank(0);

        tag = "R10"; send_msg(m2, 10, 0); send_msg(m3, 36, 0);
        rd(4'h6); rd_bank(0); rd_bank(1);

        tag = "R9 race"; reg_rd = 1; reg_addr = 4'h6;
        send_msg(m1, 1, 0); reg_rd = 0; @(negedge clk);
        rd(4'h6); rd(4'h6);
        send_msg(m1, 36, 0);

        tag = "R1"; mode_slc96 = 0;
        send_msg(m2, 36, 0); send_ones(8);
        rd(4'h6); rd_bank(1); rd_bank(0);
        mode_slc96 = 1;

        tag = "R7"; wr(8'h07);
        send_msg(m3, 5, 0); send_ones(6);
        repeat (2) @(negedge clk);
        rd(4'h6);
        send_msg(m2, 36, 0);
        rd(4'h6); rd_bank(0); rd_bank(1);
        wr(8'h87);
        send_msg(m2, 36, 0);
        rd(4'h6); rd(4'h7); rd_bank(0); rd_bank(1);

        tag = "R8"; blk_irq_en = 0;
        send_msg(m3, 36, 0);
        repeat (2) @(negedge clk);
        blk_irq_en = 1; @(negedge clk);
        wr(8'h00); @(negedge clk);
        wr(8'h02); @(negedge clk);
        rd(4'h6); rd(4'h7);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule